// File: doc/BRIEF.md
# Coprocessor Escape Instruction Framer

The framer sits between a CPU-side instruction byte queue and a numeric coprocessor's decoder. It takes one byte per input handshake and locates escape instructions, whose first byte carries the tag 11011 in its top five bits. It skips an optional WAIT prefix (0x9B), collects the addressing byte that follows and any displacement bytes. For each complete instruction it emits one decoded record: layout form (1 to 5), the opcode fragments, MOD, R/M, the middle field, the memory operand format, the result destination bit, the displacement length and the 16-bit displacement. Any other byte is passed through as a one-byte record marked as non-coprocessor traffic.

Both stream edges use valid/ready. A byte is consumed on a cycle where `in_valid` and `in_ready` are both high. A record is presented with `out_valid` and stays frozen until the cycle where `out_ready` is high. While a record waits, `in_ready` is low, so no byte is consumed. After a WAIT, if the next byte is not an escape byte, the framer refuses that byte and emits a WAIT-only record. The refused byte is then parsed fresh once that record leaves. Reset is synchronous and active high.

Top module: `esc_framer`

## Requirements
- R1: A byte whose bits [7:3] equal 11011 starts an instruction. Its record has `out_kind` = 0 and `out_raw` equal to that first byte. Every such instruction takes at least two bytes.
- R2: A byte in the idle state that is neither an escape byte nor 0x9B yields exactly one record with `out_kind` = 2, `out_raw` equal to the byte and `out_wait` = 0.
- R3: A 0x9B byte directly followed by an escape instruction is absorbed as a prefix, and that instruction's record has `out_wait` = 1. Records without the prefix have `out_wait` = 0.
- R4: A 0x9B byte followed by a non-escape byte first yields a record with `out_kind` = 1 and `out_raw` = 0x9B. The following byte is then parsed from the idle state, and that includes another 0x9B.
- R5: When MOD (second byte bits [7:6]) is 11, the form is decided as follows. First byte 0xD9 with second byte bits [7:5] = 111 gives form 4. First byte 0xDB with second byte bits [7:5] = 111 gives form 5. Every other case gives form 3.
- R6: When MOD is not 11, the form is 1 if bit 0 of the first byte is 1, and 2 if it is 0.
- R7: The displacement length `out_disp_len` is set by MOD and R/M (second byte bits [2:0]). MOD=01 gives 1. MOD=10 gives 2. MOD=00 with R/M=110 gives 2. Any other MOD=00 case gives 0. Forms 3, 4 and 5 always give 0.
- R8: `out_disp` takes the low displacement byte first. A one-byte displacement is sign-extended to 16 bits, and a length of 0 gives 0.
- R9: In form 2, `out_fmt` equals first byte bits [2:1] (00 short real, 01 short integer, 10 long real, 11 word integer). In every other record it is 0.
- R10: In form 3, `out_rdest` equals first byte bit 2 (0 = stack top, 1 = other register). In every other record it is 0.
- R11: While `out_valid` is high and `out_ready` is low, every record output holds steady and `in_ready` is low.
- R12: A synchronous reset clears `out_valid`, raises `in_ready` and discards any partly collected instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Framer accepts the byte this cycle |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 2 | 0 instruction, 1 lone WAIT, 2 non-coprocessor byte |
| out_wait | output | 1 | Instruction had a WAIT prefix |
| out_form | output | 3 | Layout form 1..5, 0 for non-instruction records |
| out_esc_op | output | 3 | First byte bits [2:0] |
| out_mod | output | 2 | Second byte bits [7:6] |
| out_mid | output | 3 | Second byte bits [5:3] |
| out_rm | output | 3 | Second byte bits [2:0] (R/M or register index) |
| out_fmt | output | 2 | Memory operand format (form 2) |
| out_rdest | output | 1 | Result destination bit (form 3) |
| out_disp_len | output | 2 | Number of displacement bytes |
| out_disp | output | 16 | Displacement value |
| out_raw | output | 8 | First byte of the record |

## Verification
The assertions watch every cycle for these properties. A record must stay frozen while it is stalled. Instruction records must carry the escape tag in `out_raw`. Pass-through records must never carry it. Forms 3 to 5 must report no displacement. The format field must stay zero outside form 2. A one-byte displacement must be sign-extended. Only the bench scenarios can show the properties that depend on the byte sequence. These are: the correct form and displacement for each concrete encoding, the splitting of a WAIT followed by a stray byte into two records, and the recovery when reset lands in the middle of an instruction.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int BYTE_W = 8;
  localparam int DISP_W = 2 * BYTE_W;
  localparam logic [4:0] ESC_TAG   = 5'b11011;
  localparam logic [7:0] WAIT_CODE = 8'h9B;
  localparam logic [7:0] FIRST_F4  = 8'hD9;
  localparam logic [7:0] FIRST_F5  = 8'hDB;

  typedef enum logic [1:0] {
    REC_INSTR = 2'd0,
    REC_WAIT  = 2'd1,
    REC_OTHER = 2'd2
  } rec_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAITED, S_ESC, S_LO, S_HI
  } fr_state_e;

  typedef struct packed {
    logic [2:0] form;
    logic [1:0] dlen;
    logic [1:0] fmt;
    logic       rdest;
  } dec_t;
endpackage

// File: rtl/esc_decode.sv
module esc_decode
  import esc_pkg::*;
(
  input  logic [BYTE_W-1:0] first,
  input  logic [BYTE_W-1:0] second,
  output dec_t              dec
);
  logic [1:0] md;
  logic [2:0] rm;
  assign md = second[7:6];
  assign rm = second[2:0];

  always_comb begin
    dec = '0;
    if (md == 2'b11) begin
      if (first == FIRST_F4 && second[7:5] == 3'b111)      dec.form = 3'd4;
      else if (first == FIRST_F5 && second[7:5] == 3'b111) dec.form = 3'd5;
      else                                                 dec.form = 3'd3;
      dec.dlen = 2'd0;
    end else begin
      dec.form = first[0] ? 3'd1 : 3'd2;
      case (md)
        2'b01:   dec.dlen = 2'd1;
        2'b10:   dec.dlen = 2'd2;
        default: dec.dlen = (rm == 3'b110) ? 2'd2 : 2'd0;
      endcase
    end
    dec.fmt   = (dec.form == 3'd2) ? first[2:1] : 2'b00;
    dec.rdest = (dec.form == 3'd3) ? first[2]   : 1'b0;
  end
endmodule

// File: rtl/esc_disp_join.sv
module esc_disp_join
  import esc_pkg::*;
#(
  parameter bit SIGN_EXT_SHORT = 1'b1
) (
  input  logic [1:0]        dlen,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic [DISP_W-1:0] disp
);
  logic [BYTE_W-1:0] short_hi;

  generate
    if (SIGN_EXT_SHORT) begin : g_sext
      assign short_hi = {BYTE_W{lo[BYTE_W-1]}};
    end else begin : g_zext
      assign short_hi = '0;
    end
  endgenerate

  always_comb begin
    case (dlen)
      2'd1:    disp = {short_hi, lo};
      2'd2:    disp = {hi, lo};
      default: disp = '0;
    endcase
  end
endmodule

// File: rtl/esc_framer.sv
module esc_framer
  import esc_pkg::*;
#(
  parameter bit SIGN_EXT_SHORT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_kind,
  output logic        out_wait,
  output logic [2:0]  out_form,
  output logic [2:0]  out_esc_op,
  output logic [1:0]  out_mod,
  output logic [2:0]  out_mid,
  output logic [2:0]  out_rm,
  output logic [1:0]  out_fmt,
  output logic        out_rdest,
  output logic [1:0]  out_disp_len,
  output logic [15:0] out_disp,
  output logic [7:0]  out_raw
);
  fr_state_e          state;
  logic [BYTE_W-1:0]  first_q, second_q, lo_q;
  logic               wait_q;

  logic               is_esc, is_wait, hold, take, emit_lone;
  logic [BYTE_W-1:0]  sec_sel, lo_sel;
  dec_t               dec;
  logic [DISP_W-1:0]  disp_w;

  assign is_esc  = (in_byte[7:3] == ESC_TAG);
  assign is_wait = (in_byte == WAIT_CODE);

  // A WAIT followed by a stray byte: refuse the byte, emit the lone WAIT.
  assign hold      = (state == S_WAITED) && in_valid && !is_esc;
  assign in_ready  = !out_valid && !hold;
  assign take      = in_valid && in_ready;
  assign emit_lone = !out_valid && hold;

  assign sec_sel = (state == S_ESC) ? in_byte : second_q;
  assign lo_sel  = (state == S_LO)  ? in_byte : lo_q;

  esc_decode u_dec (
    .first  (first_q),
    .second (sec_sel),
    .dec    (dec)
  );

  esc_disp_join #(.SIGN_EXT_SHORT(SIGN_EXT_SHORT)) u_disp (
    .dlen (dec.dlen),
    .lo   (lo_sel),
    .hi   (in_byte),
    .disp (disp_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      first_q      <= '0;
      second_q     <= '0;
      lo_q         <= '0;
      wait_q       <= 1'b0;
      out_valid    <= 1'b0;
      out_kind     <= '0;
      out_wait     <= 1'b0;
      out_form     <= '0;
      out_esc_op   <= '0;
      out_mod      <= '0;
      out_mid      <= '0;
      out_rm       <= '0;
      out_fmt      <= '0;
      out_rdest    <= 1'b0;
      out_disp_len <= '0;
      out_disp     <= '0;
      out_raw      <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (emit_lone) begin
        out_valid    <= 1'b1;
        out_kind     <= REC_WAIT;
        out_wait     <= 1'b0;
        out_form     <= '0;
        out_esc_op   <= '0;
        out_mod      <= '0;
        out_mid      <= '0;
        out_rm       <= '0;
        out_fmt      <= '0;
        out_rdest    <= 1'b0;
        out_disp_len <= '0;
        out_disp     <= '0;
        out_raw      <= WAIT_CODE;
        wait_q       <= 1'b0;
        state        <= S_IDLE;
      end else if (take) begin
        case (state)
          S_IDLE: begin
            if (is_wait) begin
              wait_q <= 1'b1;
              state  <= S_WAITED;
            end else if (is_esc) begin
              first_q <= in_byte;
              wait_q  <= 1'b0;
              state   <= S_ESC;
            end else begin
              out_valid    <= 1'b1;
              out_kind     <= REC_OTHER;
              out_wait     <= 1'b0;
              out_form     <= '0;
              out_esc_op   <= '0;
              out_mod      <= '0;
              out_mid      <= '0;
              out_rm       <= '0;
              out_fmt      <= '0;
              out_rdest    <= 1'b0;
              out_disp_len <= '0;
              out_disp     <= '0;
              out_raw      <= in_byte;
            end
          end
          S_WAITED: begin
            first_q <= in_byte;
            state   <= S_ESC;
          end
          S_ESC: begin
            second_q <= in_byte;
            state    <= (dec.dlen == 2'd0) ? S_IDLE : S_LO;
          end
          S_LO: begin
            lo_q  <= in_byte;
            state <= (dec.dlen == 2'd1) ? S_IDLE : S_HI;
          end
          default: state <= S_IDLE;
        endcase

        if ((state == S_ESC && dec.dlen == 2'd0) ||
            (state == S_LO  && dec.dlen == 2'd1) ||
            (state == S_HI)) begin
          out_valid    <= 1'b1;
          out_kind     <= REC_INSTR;
          out_wait     <= wait_q;
          out_form     <= dec.form;
          out_esc_op   <= first_q[2:0];
          out_mod      <= sec_sel[7:6];
          out_mid      <= sec_sel[5:3];
          out_rm       <= sec_sel[2:0];
          out_fmt      <= dec.fmt;
          out_rdest    <= dec.rdest;
          out_disp_len <= dec.dlen;
          out_disp     <= disp_w;
          out_raw      <= first_q;
        end
      end
    end
  end
endmodule

// File: rtl/esc_framer_chk.sv
module esc_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic        out_wait,
  input logic [2:0]  out_form,
  input logic [1:0]  out_fmt,
  input logic [1:0]  out_disp_len,
  input logic [15:0] out_disp,
  input logic [7:0]  out_raw
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_form) && $stable(out_disp) && $stable(out_raw)));

  // R11
  stall_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R1
  instr_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd0) |-> (out_raw[7:3] == 5'b11011));

  // R2
  other_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd2) |-> (out_raw[7:3] != 5'b11011 && !out_wait));

  // R7
  reg_form_nodisp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_form >= 3'd3) |-> (out_disp_len == 2'd0));

  // R9
  fmt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_form != 3'd2) |-> (out_fmt == 2'b00));

  // R8
  short_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_disp_len == 2'd1) |-> (out_disp[15:8] == {8{out_disp[7]}}));
endmodule

bind esc_framer esc_framer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_kind     (out_kind),
  .out_wait     (out_wait),
  .out_form     (out_form),
  .out_fmt      (out_fmt),
  .out_disp_len (out_disp_len),
  .out_disp     (out_disp),
  .out_raw      (out_raw)
);

// File: tb/sim_esc_framer.sv
module sim_esc_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic        out_wait;
  logic [2:0]  out_form;
  logic [2:0]  out_esc_op;
  logic [1:0]  out_mod;
  logic [2:0]  out_mid;
  logic [2:0]  out_rm;
  logic [1:0]  out_fmt;
  logic        out_rdest;
  logic [1:0]  out_disp_len;
  logic [15:0] out_disp;
  logic [7:0]  out_raw;

  always #5 clk = ~clk;

  esc_framer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_wait(out_wait), .out_form(out_form),
    .out_esc_op(out_esc_op), .out_mod(out_mod), .out_mid(out_mid),
    .out_rm(out_rm), .out_fmt(out_fmt), .out_rdest(out_rdest),
    .out_disp_len(out_disp_len), .out_disp(out_disp), .out_raw(out_raw)
  );

  typedef struct packed {
    logic [2:0]  nb;
    logic [31:0] bytes;
    logic [1:0]  kind;
    logic        wt;
    logic [2:0]  form;
    logic [1:0]  fmt;
    logic        rd;
    logic [1:0]  dlen;
    logic [15:0] disp;
    logic [7:0]  raw;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{3'd2, 32'hD9C00000, 2'd0, 1'b0, 3'd3, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hD9},
    '{3'd2, 32'hDCC10000, 2'd0, 1'b0, 3'd3, 2'd0, 1'b1, 2'd0, 16'h0000, 8'hDC},
    '{3'd2, 32'hD9E80000, 2'd0, 1'b0, 3'd4, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hD9},
    '{3'd2, 32'hDBE30000, 2'd0, 1'b0, 3'd5, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hDB},
    '{3'd4, 32'hD8063412, 2'd0, 1'b0, 3'd2, 2'd0, 1'b0, 2'd2, 16'h1234, 8'hD8},
    '{3'd3, 32'hDE47F000, 2'd0, 1'b0, 3'd2, 2'd3, 1'b0, 2'd1, 16'hFFF0, 8'hDE},
    '{3'd4, 32'hDD867856, 2'd0, 1'b0, 3'd1, 2'd0, 1'b0, 2'd2, 16'h5678, 8'hDD},
    '{3'd2, 32'hD9070000, 2'd0, 1'b0, 3'd1, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hD9},
    '{3'd3, 32'hDA451000, 2'd0, 1'b0, 3'd2, 2'd1, 1'b0, 2'd1, 16'h0010, 8'hDA},
    '{3'd3, 32'h9BDBE200, 2'd0, 1'b1, 3'd5, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hDB},
    '{3'd3, 32'h9BD93800, 2'd0, 1'b1, 3'd1, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hD9},
    '{3'd1, 32'h55000000, 2'd2, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0, 16'h0000, 8'h55},
    '{3'd2, 32'hDFF00000, 2'd0, 1'b0, 3'd3, 2'd0, 1'b1, 2'd0, 16'h0000, 8'hDF},
    '{3'd2, 32'hDBC50000, 2'd0, 1'b0, 3'd3, 2'd0, 1'b0, 2'd0, 16'h0000, 8'hDB},
    '{3'd4, 32'hD92EFF80, 2'd0, 1'b0, 3'd1, 2'd0, 1'b0, 2'd2, 16'h80FF, 8'hD9}
  };

  // captured records
  int          ncap = 0;
  logic [1:0]  c_kind [64];
  logic        c_wt   [64];
  logic [2:0]  c_form [64];
  logic [1:0]  c_fmt  [64];
  logic        c_rd   [64];
  logic [1:0]  c_dlen [64];
  logic [15:0] c_disp [64];
  logic [7:0]  c_raw  [64];

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && ncap < 64) begin
      c_kind[ncap] <= out_kind;
      c_wt[ncap]   <= out_wait;
      c_form[ncap] <= out_form;
      c_fmt[ncap]  <= out_fmt;
      c_rd[ncap]   <= out_rdest;
      c_dlen[ncap] <= out_disp_len;
      c_disp[ncap] <= out_disp;
      c_raw[ncap]  <= out_raw;
      ncap <= ncap + 1;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_recs(input int n);
    int t = 0;
    while (ncap < n && t < 50) begin
      @(posedge clk);
      t++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rec(input int i, input logic [1:0] k, input logic w,
                            input logic [2:0] f, input logic [7:0] r,
                            input string req);
    chk(c_kind[i] == k, req, 32'(c_kind[i]), 32'(k));
    chk(c_wt[i] == w,   req, 32'(c_wt[i]),   32'(w));
    chk(c_form[i] == f, req, 32'(c_form[i]), 32'(f));
    chk(c_raw[i] == r,  req, 32'(c_raw[i]),  32'(r));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(out_valid == 1'b0, "R12", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1,  "R12", 32'(in_ready),  32'd1);
    @(posedge clk);
    #1;

    for (int v = 0; v < NV; v++) begin
      base = ncap;
      for (int b = 0; b < int'(VT[v].nb); b++)
        send(VT[v].bytes[31-8*b -: 8]);
      wait_recs(base + 1);
      chk(ncap == base + 1, "R1", 32'(ncap - base), 32'd1);
      chk(c_kind[base] == VT[v].kind, (VT[v].kind == 2'd2) ? "R2" : "R1",
          32'(c_kind[base]), 32'(VT[v].kind));
      chk(c_raw[base] == VT[v].raw, "R1", 32'(c_raw[base]), 32'(VT[v].raw));
      chk(c_wt[base] == VT[v].wt, "R3", 32'(c_wt[base]), 32'(VT[v].wt));
      chk(c_form[base] == VT[v].form, (VT[v].form >= 3'd3) ? "R5" : "R6",
          32'(c_form[base]), 32'(VT[v].form));
      chk(c_fmt[base] == VT[v].fmt, "R9", 32'(c_fmt[base]), 32'(VT[v].fmt));
      chk(c_rd[base] == VT[v].rd, "R10", 32'(c_rd[base]), 32'(VT[v].rd));
      chk(c_dlen[base] == VT[v].dlen, "R7", 32'(c_dlen[base]), 32'(VT[v].dlen));
      chk(c_disp[base] == VT[v].disp, "R8", 32'(c_disp[base]), 32'(VT[v].disp));
    end

    // R4: WAIT then stray byte
    base = ncap;
    send(8'h9B);
    send(8'h55);
    wait_recs(base + 2);
    chk(ncap == base + 2, "R4", 32'(ncap - base), 32'd2);
    expect_rec(base,     2'd1, 1'b0, 3'd0, 8'h9B, "R4");
    expect_rec(base + 1, 2'd2, 1'b0, 3'd0, 8'h55, "R4");

    // R4: WAIT WAIT escape -> lone WAIT, then prefixed instruction
    base = ncap;
    send(8'h9B);
    send(8'h9B);
    send(8'hD9);
    send(8'hC0);
    wait_recs(base + 2);
    chk(ncap == base + 2, "R4", 32'(ncap - base), 32'd2);
    expect_rec(base,     2'd1, 1'b0, 3'd0, 8'h9B, "R4");
    expect_rec(base + 1, 2'd0, 1'b1, 3'd3, 8'hD9, "R4");

    // R11: back-pressure
    base = ncap;
    out_ready = 1'b0;
    send(8'hD9);
    send(8'hE8);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R11", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0,  "R11", 32'(in_ready),  32'd0);
    chk(out_form == 3'd4,  "R11", 32'(out_form),  32'd4);
    chk(out_raw == 8'hD9,  "R11", 32'(out_raw),   32'hD9);
    chk(ncap == base,      "R11", 32'(ncap - base), 32'd0);
    @(posedge clk);
    #1 out_ready = 1'b1;
    wait_recs(base + 1);
    chk(ncap == base + 1, "R11", 32'(ncap - base), 32'd1);
    expect_rec(base, 2'd0, 1'b0, 3'd4, 8'hD9, "R11");

    // R12: reset in the middle of an instruction
    base = ncap;
    send(8'hD8);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1,  "R12", 32'(in_ready),  32'd1);
    @(posedge clk);
    #1;
    send(8'hD9);
    send(8'hC0);
    wait_recs(base + 1);
    chk(ncap == base + 1, "R12", 32'(ncap - base), 32'd1);
    expect_rec(base, 2'd0, 1'b0, 3'd3, 8'hD9, "R12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule